// File: doc/BRIEF.md
# Serial Peripheral Master with Frame FIFOs

This block is a memory-mapped serial peripheral (SPI) master. Software reaches it over a 32-bit register bus that accepts one access per cycle and returns read data one cycle after the read strobe. Each 8-bit frame written to the transmit data port goes into a 16-entry transmit FIFO. The shift engine sends the frames out on MOSI, one after another, with a serial clock of one quarter of the system clock. For every frame it sends, it captures one frame from MISO into a 16-entry receive FIFO. To read only, software writes 0xFF frames as filler.

A control register sets clock polarity, clock phase, bit order and an internal loopback from MOSI to the receiver. It also holds an inhibit bit. While inhibit is set, software can fill the transmit FIFO and nothing moves. Clearing inhibit sends the whole queue as one burst.

The slave-select register is active low and holds one low bit. In manual mode its value drives the select pins at all times. In automatic mode the pins take that value only while frames are shifting. The bus has no back-pressure: a write to a full transmit FIFO is dropped, and a read of an empty receive FIFO returns zero and removes nothing.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x64) reads 0x25, the control register (offset 0x60) reads 0, the select pins are all high and the serial clock is low. Status bits, counted from the LSB, are: bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full, bit4 mode fault, bit5 slave flag. The slave flag always reads 1.
- R2: Control bits, counted from the LSB, are: bit0 loopback, bit1 enable, bit2 master, bit3 CPOL, bit4 CPHA, bit5 transmit flush, bit6 receive flush, bit7 manual select, bit8 inhibit, bit9 LSB first. While inhibit is set, writes to the transmit port (offset 0x68) still queue frames, but no serial clock edge occurs. Clearing inhibit while enable and master are both set sends every queued frame.
- R3: Each frame sent pushes exactly one frame into the receive FIFO, which is read from the low byte at offset 0x6C. With loopback set, the received frames equal the sent frames, in order.
- R4: The serial clock idles at the CPOL level. With CPHA=0, MOSI is valid at the edge leaving the idle level. With CPHA=1, MOSI is valid at the edge returning to the idle level. With loopback clear, MISO is sampled on that same edge.
- R5: With bit order 0, bit 7 of each frame is sent first. With bit order 1, bit 0 is sent first. The receiver assembles each frame in the same order.
- R6: The transmit-empty flag rises only after the last bit of the final frame has been sampled. When software sees it set, every received frame can already be read.
- R7: Each FIFO holds 16 frames. The full flag of the transmit FIFO sets at 16 entries. A 17th write is dropped, and the receive FIFO then holds exactly 16 frames with its full flag set.
- R8: A read of the empty receive FIFO returns 0 and changes nothing. Writing 1 to a flush bit empties that FIFO in the cycle of the write. A flush bit always reads back as 0. Frames flushed from the transmit FIFO are never sent.
- R9: The slave-select register is at offset 0x70 and reads with its unused upper bits set to 1. In automatic mode, the pins follow the register only while frames are shifting and are all high otherwise. In manual mode, the pins follow the register at all times.
- R10: Writing 0x0000000A to offset 0x40 returns the control register, the select register, both FIFOs and the flags to their reset values. A write of any other value to offset 0x40 has no effect.
- R11: Writing a select value with more than one low bit sets the mode-fault status bit. A read of the status register returns the bit and then clears it. A select value with one low bit does not set it.
- R12: While shifting, the serial clock has a period of 4 system clocks and each level lasts 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | Marks the cycle in which bus_rdata is valid |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave-select pins |

## Verification
The bench runs every combination of polarity, phase and bit order. For each one, a monitor samples MOSI on the edge that mode defines, and a slave model echoes the inverted MOSI. A design with a swapped edge or a reversed bit order therefore reports wrong frames on both the wire and the receive side. Directed cases cover the following, each with the failure it would expose:
- The 17th write into a full queue, which a design without an overflow guard would wrap onto the oldest entry.
- A read of the empty receive FIFO, which a careless design would let pop garbage.
- A flush of a preloaded queue followed by release of inhibit, which would show up as stray frames.
- The moment transmit-empty rises, which a design that flags it at the last load would reach while a received frame is still missing.

Randomised bursts of 1 to 16 frames in loopback check that frame order holds across back-to-back frames.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OFF_SRST = 8'h40;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_TXD  = 8'h68;
  localparam logic [7:0] OFF_RXD  = 8'h6C;
  localparam logic [7:0] OFF_SSEL = 8'h70;
  localparam logic [31:0] SRST_KEY = 32'h0000000A;

  localparam int CB_LOOP   = 0;
  localparam int CB_EN     = 1;
  localparam int CB_MST    = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CPHA   = 4;
  localparam int CB_TXFL   = 5;
  localparam int CB_RXFL   = 6;
  localparam int CB_MANUAL = 7;
  localparam int CB_INH    = 8;
  localparam int CB_LSB    = 9;
  localparam int CTRL_W    = 10;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic          do_push, do_pop;

  assign count   = wptr - rptr;
  assign empty   = (wptr == rptr);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          loopback,
  input  logic          tx_avail,
  input  logic [FW-1:0] tx_byte,
  input  logic          miso,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [FW-1:0] rx_byte,
  output logic          busy,
  output logic          sclk,
  output logic          mosi
);
  localparam int BW = $clog2(FW);
  localparam int CW = BW + 2;
  localparam logic [CW-1:0] LAST = CW'(FW * 4 - 1);

  logic [CW-1:0] cnt;
  logic [FW-1:0] txb, rxb;
  logic [BW-1:0] bi, idx;
  logic          at_last, in_bit;

  assign at_last = busy && (cnt == LAST);
  assign bi      = cnt[CW-1:2];
  assign idx     = lsb_first ? bi : (BW'(FW - 1) - bi);
  assign mosi    = busy ? txb[idx] : 1'b0;
  assign in_bit  = loopback ? mosi : miso;
  assign sclk    = busy ? (cpol ^ (cpha ? ~cnt[1] : cnt[1])) : cpol;
  assign tx_pop  = (!busy || at_last) && go && tx_avail;
  assign rx_push = at_last;
  assign rx_byte = rxb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      txb  <= '0;
      rxb  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      if (tx_pop) begin
        txb  <= tx_byte;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (at_last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (busy && cnt[1:0] == 2'd1) begin
        if (lsb_first) rxb <= {in_bit, rxb[FW-1:1]};
        else           rxb <= {rxb[FW-2:0], in_bit};
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FW    = 8,
  parameter int NSS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           bus_rvalid,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NSS-1:0]    ss_q;
  logic              modf_q;
  logic              soft_rst, wr_ctrl, wr_ssel, rd_stat, rd_rxd;
  logic              tx_flush, rx_flush;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [CNTW-1:0]   tx_count, rx_count;
  logic [FW-1:0]     tx_dout, rx_dout, rx_din;
  logic              tx_pop, rx_push, busy, go;
  logic              inhibit, manual;

  assign soft_rst = bus_wr && bus_addr == OFF_SRST && bus_wdata == SRST_KEY;
  assign wr_ctrl  = bus_wr && bus_addr == OFF_CTRL;
  assign wr_ssel  = bus_wr && bus_addr == OFF_SSEL;
  assign rd_stat  = bus_rd && bus_addr == OFF_STAT;
  assign rd_rxd   = bus_rd && bus_addr == OFF_RXD;
  assign tx_flush = soft_rst || (wr_ctrl && bus_wdata[CB_TXFL]);
  assign rx_flush = soft_rst || (wr_ctrl && bus_wdata[CB_RXFL]);
  assign inhibit  = ctrl_q[CB_INH];
  assign manual   = ctrl_q[CB_MANUAL];
  assign go       = ctrl_q[CB_EN] && ctrl_q[CB_MST] && !inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ss_q   <= '1;
      modf_q <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      ss_q   <= '1;
      modf_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q           <= bus_wdata[CTRL_W-1:0];
        ctrl_q[CB_TXFL]  <= 1'b0;
        ctrl_q[CB_RXFL]  <= 1'b0;
      end
      if (wr_ssel) ss_q <= bus_wdata[NSS-1:0];
      if (wr_ssel && $countones(~bus_wdata[NSS-1:0]) > 1) modf_q <= 1'b1;
      else if (rd_stat) modf_q <= 1'b0;
    end
  end

  spim_fifo #(.DEPTH(DEPTH), .W(FW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(bus_wr && bus_addr == OFF_TXD), .din(bus_wdata[FW-1:0]),
    .pop(tx_pop), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  spim_fifo #(.DEPTH(DEPTH), .W(FW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(rx_din),
    .pop(rd_rxd), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  spim_shift #(.FW(FW)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .go(go),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]),
    .lsb_first(ctrl_q[CB_LSB]), .loopback(ctrl_q[CB_LOOP]),
    .tx_avail(!tx_empty), .tx_byte(tx_dout), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_din),
    .busy(busy), .sclk(sclk), .mosi(mosi)
  );

  assign ss_n = (manual || busy) ? ss_q : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          OFF_CTRL: bus_rdata <= {{(32-CTRL_W){1'b0}}, ctrl_q};
          OFF_STAT: bus_rdata <= {26'd0, 1'b1, modf_q, tx_full,
                                  tx_empty && !busy, rx_full, rx_empty};
          OFF_RXD:  bus_rdata <= rx_empty ? 32'd0 : {{(32-FW){1'b0}}, rx_dout};
          OFF_SSEL: bus_rdata <= {{(32-NSS){1'b1}}, ss_q};
          default:  bus_rdata <= 32'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
  import spim_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NSS   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [7:0]               bus_addr,
  input logic [31:0]              bus_wdata,
  input logic [31:0]              bus_rdata,
  input logic                     sclk,
  input logic [NSS-1:0]           ss_n,
  input logic                     busy,
  input logic                     inhibit,
  input logic                     manual,
  input logic                     rx_empty,
  input logic [$clog2(DEPTH):0]   tx_count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= ($clog2(DEPTH)+1)'(DEPTH)); // R7

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !busy) |=> !busy); // R2

  AST_SCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk != $past(sclk)) |=> $stable(sclk)); // R12

  AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && !busy) |-> (ss_n == '1)); // R9

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_RXD && rx_empty) |=> (bus_rdata == 32'd0)); // R8

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SRST && bus_wdata == SRST_KEY) |=> (ss_n == '1 && !busy)); // R10
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sclk(sclk), .ss_n(ss_n), .busy(busy), .inhibit(inhibit),
  .manual(manual), .rx_empty(rx_empty), .tx_count(tx_count)
);

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, sclk, mosi, miso;
  logic [3:0]  ss_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txq [32];
  logic [7:0] mon [32];
  int         mon_n = 0;
  logic [7:0] mon_sh = '0;
  int         mon_bits = 0;
  logic       cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;

  assign miso = ~mosi;

  spim_ctrl u_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #10 clk = ~clk;

  always @(sclk) begin
    if (ss_n != 4'hF && ((sclk != cur_cpol) == (cur_cpha == 1'b0))) begin
      logic [7:0] nx;
      nx = cur_lsb ? {mosi, mon_sh[7:1]} : {mon_sh[6:0], mosi};
      mon_sh = nx;
      mon_bits++;
      if (mon_bits == 8) begin
        if (mon_n < 32) mon[mon_n] = nx;
        mon_n++;
        mon_bits = 0;
      end
    end
  end

  function automatic logic [31:0] exp_stat(bit rxe, bit rxf, bit txe, bit txf, bit mf);
    return {26'd0, 1'b1, mf, txf, txe, rxf, rxe};
  endfunction

  function automatic logic [31:0] exp_ctrl(bit loopb, bit cpol, bit cpha, bit manl, bit inh, bit lsb);
    return {22'd0, lsb, inh, manl, 2'b00, cpha, cpol, 1'b1, 1'b1, loopb};
  endfunction

  function automatic logic [7:0] exp_rx(bit loopb, logic [7:0] b);
    return loopb ? b : ~b;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h64, s);
      if (s[2]) return;
    end
    chk("R6 transmit-empty never rose", 0, 1);
  endtask

  task automatic mon_clear();
    mon_n = 0; mon_bits = 0; mon_sh = '0;
  endtask

  task automatic burst(bit loopb, bit cpol, bit cpha, bit lsb, int n, logic [3:0] ss);
    logic [31:0] d;
    cur_cpol = cpol; cur_cpha = cpha; cur_lsb = lsb;
    wr(8'h60, exp_ctrl(loopb, cpol, cpha, 0, 1, lsb));
    wr(8'h70, {28'hFFFFFFF, ss});
    mon_clear();
    for (int i = 0; i < n; i++) wr(8'h68, {24'd0, txq[i]});
    wr(8'h60, exp_ctrl(loopb, cpol, cpha, 0, 0, lsb));
    repeat (10) @(negedge clk);
    chk("R9 select pins during burst", ss_n, ss);
    wait_idle();
    chk("R9 select released after burst", ss_n, 4'hF);
    chk("R4 frames seen on wire", mon_n, n);
    for (int i = 0; i < n && i < 32; i++) begin
      chk(cur_lsb ? "R5 LSB-first wire frame" : "R4 wire frame", mon[i], txq[i]);
    end
    for (int i = 0; i < n; i++) begin
      rd(8'h6C, d);
      chk(loopb ? "R3 loopback receive" : "R4 echoed receive", d, {24'd0, exp_rx(loopb, txq[i])});
    end
  endtask

  initial begin
    #(20 * 190000);
    chk("watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1
    rd(8'h64, d); chk("R1 status after reset", d, 32'h25);
    rd(8'h60, d); chk("R1 control after reset", d, 0);
    chk("R1 select pins after reset", ss_n, 4'hF);
    chk("R1 sclk idle low", sclk, 0);

    // R10
    wr(8'h60, 32'h186); wr(8'h70, 32'hE);
    wr(8'h40, 32'h5);
    rd(8'h60, d); chk("R10 other value ignored", d, 32'h186);
    wr(8'h40, 32'hA);
    rd(8'h60, d); chk("R10 control cleared", d, 0);
    rd(8'h70, d); chk("R10 select cleared", d, 32'hFFFFFFFF);
    chk("R10 pins high", ss_n, 4'hF);

    // R2, R3, R6
    for (int i = 0; i < 3; i++) txq[i] = 8'($urandom);
    cur_cpol = 0; cur_cpha = 0; cur_lsb = 0;
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 1, 0));
    wr(8'h70, 32'hE);
    mon_clear();
    for (int i = 0; i < 3; i++) wr(8'h68, {24'd0, txq[i]});
    repeat (100) @(negedge clk);
    chk("R2 no frame while inhibited", mon_n + mon_bits, 0);
    rd(8'h64, d); chk("R2 status while inhibited", d, exp_stat(1, 0, 0, 0, 0));
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 0, 0));
    wait_idle();
    for (int i = 0; i < 3; i++) begin
      rd(8'h6C, d); chk("R6 frame present when empty seen", d, {24'd0, txq[i]});
    end
    rd(8'h64, d); chk("R3 one receive per send", d, exp_stat(1, 0, 1, 0, 0));

    // R4, R5: all modes, echo slave
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 4; i++) txq[i] = 8'($urandom);
      burst(0, m[0], m[1], m[2], 4, ~(4'b1 << (m % 4)));
    end

    // R12
    begin
      int c;
      cur_cpol = 0; cur_cpha = 0; cur_lsb = 0;
      wr(8'h60, exp_ctrl(1, 0, 0, 0, 1, 0));
      wr(8'h68, 32'h5A);
      wr(8'h60, exp_ctrl(1, 0, 0, 0, 0, 0));
      c = 0;
      while (!sclk && c < 50) begin @(posedge clk); #1; c++; end
      c = 0;
      while (sclk && c < 50) begin @(posedge clk); #1; c++; end
      chk("R12 high level length", c, 2);
      c = 0;
      while (!sclk && c < 50) begin @(posedge clk); #1; c++; end
      chk("R12 low level length", c, 2);
      wait_idle();
      rd(8'h6C, d); chk("R3 single frame", d, 32'h5A);
    end

    // R7
    for (int i = 0; i < 17; i++) txq[i] = 8'($urandom);
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 1, 0));
    for (int i = 0; i < 17; i++) wr(8'h68, {24'd0, txq[i]});
    rd(8'h64, d); chk("R7 transmit full", d, exp_stat(1, 0, 0, 1, 0));
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 0, 0));
    wait_idle();
    rd(8'h64, d); chk("R7 receive full", d, exp_stat(0, 1, 1, 0, 0));
    for (int i = 0; i < 16; i++) begin
      rd(8'h6C, d); chk("R7 frame order", d, {24'd0, txq[i]});
    end
    rd(8'h64, d); chk("R7 17th frame dropped", d, exp_stat(1, 0, 1, 0, 0));

    // R8
    rd(8'h6C, d); chk("R8 empty read returns 0", d, 0);
    rd(8'h64, d); chk("R8 empty read no change", d, exp_stat(1, 0, 1, 0, 0));
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 1, 0));
    for (int i = 0; i < 3; i++) wr(8'h68, 32'h33);
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 1, 0) | 32'h20);
    rd(8'h64, d); chk("R8 transmit flush", d, exp_stat(1, 0, 1, 0, 0));
    rd(8'h60, d); chk("R8 flush bit self-clears", d, exp_ctrl(1, 0, 0, 0, 1, 0));
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 0, 0));
    repeat (100) @(negedge clk);
    rd(8'h64, d); chk("R8 flushed frames not sent", d, exp_stat(1, 0, 1, 0, 0));
    wr(8'h68, 32'h11); wr(8'h68, 32'h22);
    wait_idle();
    wr(8'h60, exp_ctrl(1, 0, 0, 0, 0, 0) | 32'h40);
    rd(8'h64, d); chk("R8 receive flush", d, exp_stat(1, 0, 1, 0, 0));

    // R9 manual
    wr(8'h60, exp_ctrl(1, 0, 0, 1, 1, 0));
    wr(8'h70, 32'hD);
    repeat (2) @(negedge clk);
    chk("R9 manual pins when idle", ss_n, 4'hD);
    wr(8'h68, 32'hC3);
    wr(8'h60, exp_ctrl(1, 0, 0, 1, 0, 0));
    wait_idle();
    chk("R9 manual pins held after burst", ss_n, 4'hD);
    rd(8'h6C, d); chk("R3 manual mode receive", d, 32'hC3);

    // R11
    wr(8'h70, 32'h3);
    rd(8'h64, d); chk("R11 mode fault set", d, exp_stat(1, 0, 1, 0, 1));
    rd(8'h64, d); chk("R11 mode fault cleared by read", d, exp_stat(1, 0, 1, 0, 0));
    wr(8'h70, 32'hB);
    rd(8'h64, d); chk("R11 one-hot no fault", d, exp_stat(1, 0, 1, 0, 0));

    // random loopback bursts
    for (int it = 0; it < 12; it++) begin
      int n;
      logic [2:0] md;
      n  = 1 + int'($urandom % 16);
      md = 3'($urandom);
      for (int i = 0; i < n; i++) txq[i] = 8'($urandom);
      burst(1, md[0], md[1], md[2], n, ~(4'b1 << ($urandom % 4)));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule